// File: doc/BRIEF.md
# Byte-Lane Data Memory with Access-Size Control

This block is a small data memory addressed in bytes, built for the load/store stage of a simple processor datapath. Every access is described by a single 2-bit code that carries both the direction and the width: one code reads a full word, and the other three write a byte, a halfword or a full word. Narrow writes change only the byte lanes they address, so software can patch part of a word without a read-modify-write sequence.

Storage is an internal array of 32-bit words whose depth is a parameter. The word is picked by the address bits just above the two byte-offset bits; the address bits above the array are ignored, so the array repeats across the address space. Reads are combinational from the addressed word. Writes take effect on the rising clock edge. Word and halfword accesses must be naturally aligned. An enabled request that breaks this rule raises an error output in the same cycle and leaves the array unchanged. With the enable low, the block neither writes nor reports errors.

Top module: `lane_mem_top`

## Requirements
- R1: An active-low reset clears every stored word to zero, so every address reads 0 after reset.
- R2: While `accEn` is 0 no word changes and `alignErr` is 0, whatever the code, address and data.
- R3: Code 2'b00 reads a word and never changes the array. `alignErr` is 1 when it is enabled and `addr[1:0]` is not 0.
- R4: Code 2'b01 writes `wrData[7:0]` into byte lane `addr[1:0]` of the addressed word, with lane k at bits [8k+7:8k] (little-endian). The other three lanes keep their values. This code never raises `alignErr`.
- R5: Code 2'b10 writes `wrData[15:0]` into bits [15:0] when `addr[1]` is 0 and into bits [31:16] when `addr[1]` is 1, and leaves the other half unchanged. When `addr[0]` is 1 it raises `alignErr` and writes nothing.
- R6: Code 2'b11 writes all 32 bits of `wrData`. When `addr[1:0]` is not 0 it raises `alignErr` and writes nothing.
- R7: A write takes effect on the rising clock edge. Before that edge `rdData` still shows the old word, and after it `rdData` shows the new one.
- R8: The word index is `addr[IDX_W+1:2]` with IDX_W = log2(DEPTH). The higher address bits have no effect, so two addresses that differ only there reach the same word.
- R9: `rdData` follows a change of `addr` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset that clears the array |
| accEn | input | 1 | Access enable |
| sizeCode | input | 2 | 00 word read, 01 byte write, 10 halfword write, 11 word write |
| addr | input | 32 | Byte address |
| wrData | input | 32 | Write data, taken from the low bits for narrow writes |
| rdData | output | 32 | Addressed word, combinational |
| alignErr | output | 1 | Enabled request is misaligned for its width |

## Verification
Every word is first written whole and read back, so that a wrong index or a stuck bit shows up apart from any lane-steering fault. Byte writes to each of the four lanes and halfword writes to both halves then show whether the lane order or the size decode is wrong. Misaligned offsets for every width, disabled requests with all four codes, and addresses with high bits set each isolate one gating rule: the alignment check, the enable, and the dropping of the high address bits. A long stretch of random codes, addresses and data, checked against a behavioural byte-level model on every cycle, then mixes all of these. Extra reads that move the address without a clock edge check the combinational read path.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;

  localparam int WORD_BITS  = 32;
  localparam int LANE_BITS  = 8;
  localparam int LANE_COUNT = WORD_BITS / LANE_BITS;

  // Access code: direction and width in one field
  typedef enum logic [1:0] {
    SZ_RD_WORD = 2'b00,
    SZ_WR_BYTE = 2'b01,
    SZ_WR_HALF = 2'b10,
    SZ_WR_WORD = 2'b11
  } sizeCode_e;

  // How write data is spread across the byte lanes
  typedef enum logic [1:0] {
    REP_BYTE = 2'b00,
    REP_HALF = 2'b01,
    REP_WORD = 2'b10
  } laneRep_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                  wrEn;
    logic [LANE_COUNT-1:0] laneMask;
    laneRep_e              rep;
  } memStrobe_t;

endpackage

// File: rtl/lane_mem_ctrl.sv
module lane_mem_ctrl
  import lane_mem_pkg::*;
(
  input  logic       accEn,
  input  logic [1:0] sizeCode,
  input  logic [1:0] byteOfs,
  output memStrobe_t strobe,
  output logic       misalign
);

  sizeCode_e code;
  logic      badAlign;
  logic      isWrite;

  assign code = sizeCode_e'(sizeCode);

  // Natural-alignment rule per access width
  always_comb begin
    case (code)
      SZ_RD_WORD, SZ_WR_WORD: badAlign = (byteOfs != 2'b00);
      SZ_WR_HALF:             badAlign = byteOfs[0];
      default:                badAlign = 1'b0;
    endcase
  end

  assign isWrite  = (code != SZ_RD_WORD);
  assign misalign = accEn && badAlign;

  always_comb begin
    strobe.wrEn     = accEn && isWrite && !badAlign;
    strobe.laneMask = '0;
    strobe.rep      = REP_WORD;
    case (code)
      SZ_WR_BYTE: begin
        strobe.rep      = REP_BYTE;
        strobe.laneMask = 4'b0001 << byteOfs;
      end
      SZ_WR_HALF: begin
        strobe.rep      = REP_HALF;
        strobe.laneMask = byteOfs[1] ? 4'b1100 : 4'b0011;
      end
      SZ_WR_WORD: begin
        strobe.rep      = REP_WORD;
        strobe.laneMask = 4'b1111;
      end
      default: begin
        strobe.rep      = REP_WORD;
        strobe.laneMask = 4'b0000;
      end
    endcase
    if (!strobe.wrEn) strobe.laneMask = '0;
  end

endmodule

// File: rtl/lane_mem_dp.sv
module lane_mem_dp
  import lane_mem_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  memStrobe_t           strobe,
  input  logic [IDX_W-1:0]     wordIdx,
  input  logic [WORD_BITS-1:0] wrData,
  output logic [WORD_BITS-1:0] rdData
);

  logic [WORD_BITS-1:0] laneData;

  // Replicate narrow data so every lane sees its slice
  always_comb begin
    case (strobe.rep)
      REP_BYTE: laneData = {LANE_COUNT{wrData[LANE_BITS-1:0]}};
      REP_HALF: laneData = {(LANE_COUNT/2){wrData[2*LANE_BITS-1:0]}};
      default:  laneData = wrData;
    endcase
  end

  // One byte-wide bank per lane
  for (genvar g = 0; g < LANE_COUNT; g++) begin : gLane
    logic [LANE_BITS-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (strobe.wrEn && strobe.laneMask[g]) begin
        cells[wordIdx] <= laneData[g*LANE_BITS +: LANE_BITS];
      end
    end

    assign rdData[g*LANE_BITS +: LANE_BITS] = cells[wordIdx];
  end

endmodule

// File: rtl/lane_mem_top.sv
module lane_mem_top
  import lane_mem_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accEn,
  input  logic [1:0]  sizeCode,
  input  logic [31:0] addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        alignErr
);

  localparam int IDX_W  = $clog2(DEPTH);
  localparam int ADDR_W = 32;

  memStrobe_t       strobe;
  logic [IDX_W-1:0] wordIdx;
  logic             unusedHighAddr;

  assign wordIdx        = addr[IDX_W+1:2];
  assign unusedHighAddr = ^addr[ADDR_W-1:IDX_W+2];

  lane_mem_ctrl ctrl_i (
    .accEn    (accEn),
    .sizeCode (sizeCode),
    .byteOfs  (addr[1:0]),
    .strobe   (strobe),
    .misalign (alignErr)
  );

  lane_mem_dp #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wordIdx (wordIdx),
    .wrData  (wrData),
    .rdData  (rdData)
  );

endmodule

// File: rtl/lane_mem_chk.sv
module lane_mem_chk (
  input logic        clk,
  input logic        rstN,
  input logic        accEn,
  input logic [1:0]  sizeCode,
  input logic [31:0] addr,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        alignErr
);

  AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    !accEn |-> !alignErr); // R2

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !accEn ##1 $stable(addr) |-> $stable(rdData)); // R2

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && sizeCode == 2'b00) ##1 $stable(addr) |-> $stable(rdData)); // R3

  AST_READ_MISALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && sizeCode == 2'b00 && addr[1:0] != 2'b00) |-> alignErr); // R3

  AST_BYTE_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (sizeCode == 2'b01) |-> !alignErr); // R4

  AST_HALF_ODD_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && sizeCode == 2'b10) |-> (alignErr == addr[0])); // R5

  AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && sizeCode == 2'b11) |-> (alignErr == (addr[1:0] != 2'b00))); // R6

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    alignErr ##1 $stable(addr) |-> $stable(rdData)); // R6

  AST_WORD_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && sizeCode == 2'b11 && addr[1:0] == 2'b00) ##1 $stable(addr)
      |-> (rdData == $past(wrData))); // R7

endmodule

bind lane_mem_top lane_mem_chk chk_i (.*);

// File: tb/lane_mem_top_tb.sv
module lane_mem_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int IDX_W      = $clog2(DEPTH);

  logic        clk;
  logic        rstN;
  logic        accEn;
  logic [1:0]  sizeCode;
  logic [31:0] addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        alignErr;

  logic [31:0] model [DEPTH];
  int checkCount = 0;
  int failCount  = 0;

  lane_mem_top #(.DEPTH(DEPTH)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .accEn    (accEn),
    .sizeCode (sizeCode),
    .addr     (addr),
    .wrData   (wrData),
    .rdData   (rdData),
    .alignErr (alignErr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic int idxOf(input logic [31:0] a);
    return int'(a[IDX_W+1:2]);
  endfunction

  // One access: drive after falling edge, check before the rising edge,
  // then update the reference model at the rising edge.
  task automatic step(input bit en, input logic [1:0] code, input logic [31:0] a,
                      input logic [31:0] d, input string req);
    bit bad;
    int ix;
    @(negedge clk);
    accEn = en; sizeCode = code; addr = a; wrData = d;
    #(CLK_PERIOD/4);
    ix  = idxOf(a);
    bad = (code == 2'b00 || code == 2'b11) ? (a[1:0] != 2'b00) :
          (code == 2'b10) ? a[0] : 1'b0;
    check1({req, " alignErr"}, alignErr, en && bad);
    check32({req, " rdData"}, rdData, model[ix]);
    @(posedge clk);
    if (en && !bad) begin
      case (code)
        2'b01: model[ix][{a[1:0], 3'b000} +: 8]  = d[7:0];
        2'b10: model[ix][{a[1], 4'b0000} +: 16] = d[15:0];
        2'b11: model[ix] = d;
        default: ;
      endcase
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual still running, expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    rstN = 1'b0; accEn = 1'b0; sizeCode = 2'b00; addr = '0; wrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: everything reads zero after reset
    for (int i = 0; i < DEPTH; i++) step(1, 2'b00, i*4, 32'hDEAD_BEEF, "R1 reset read");

    // R6 R7: whole-word writes, old value visible before the edge
    for (int i = 0; i < DEPTH; i++)
      step(1, 2'b11, i*4, 32'hA500_0000 ^ (i * 32'h0103_0507), "R6 R7 word write");
    for (int i = 0; i < DEPTH; i++) step(1, 2'b00, i*4, '0, "R3 word read");

    // R4: byte into each lane, high data bits must not leak
    for (int l = 0; l < 4; l++) begin
      step(1, 2'b01, 3*4 + l, 32'hFFFF_FF10 | l, "R4 R7 byte write");
      step(1, 2'b00, 3*4, '0, "R4 byte readback");
    end
    step(1, 2'b01, 9*4 + 3, 32'h0000_007E, "R4 byte lane3");
    step(1, 2'b00, 9*4, '0, "R4 lane3 readback");

    // R5: both halves, then odd offsets
    step(1, 2'b10, 5*4,     32'hCCCC_1234, "R5 half low");
    step(1, 2'b00, 5*4,     '0,            "R5 half low readback");
    step(1, 2'b10, 5*4 + 2, 32'hDDDD_ABCD, "R5 half high");
    step(1, 2'b00, 5*4,     '0,            "R5 half high readback");
    step(1, 2'b10, 5*4 + 1, 32'h0000_5555, "R5 half misaligned 1");
    step(1, 2'b10, 5*4 + 3, 32'h0000_6666, "R5 half misaligned 3");
    step(1, 2'b00, 5*4,     '0,            "R5 unchanged after misaligned");

    // R6 / R3: misaligned word write and read
    for (int o = 1; o < 4; o++) begin
      step(1, 2'b11, 6*4 + o, 32'h1357_9BDF, "R6 word misaligned");
      step(1, 2'b00, 6*4 + o, '0,            "R3 read misaligned");
    end
    step(1, 2'b00, 6*4, '0, "R6 unchanged after misaligned");

    // R2: disabled requests of every code
    for (int c = 0; c < 4; c++) step(0, 2'(c), 8*4 + c, 32'h0BAD_F00D, "R2 disabled");
    step(0, 2'b11, 8*4 + 1, 32'h0BAD_F00D, "R2 disabled misaligned no error");
    step(1, 2'b00, 8*4, '0, "R2 unchanged after disabled");

    // R8: high address bits are ignored
    step(1, 2'b11, 32'hFFFF_FF00 | (7*4), 32'h7777_AAAA, "R8 alias word write");
    step(1, 2'b00, 7*4, '0, "R8 alias readback");
    step(1, 2'b01, 32'h8000_0000 | (7*4 + 2), 32'h0000_0042, "R8 alias byte write");
    step(1, 2'b00, 32'h0123_4000 | (7*4), '0, "R8 alias readback 2");

    // R9: read follows the address within one low phase
    @(negedge clk);
    accEn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      addr = i*4*3;
      #1;
      check32("R9 combinational read", rdData, model[idxOf(i*4*3)]);
    end

    // Mixed random traffic against the model
    for (int n = 0; n < 600; n++)
      step(($urandom % 8) != 0, 2'($urandom), $urandom, $urandom, "R3 R4 R5 R6 mixed");

    for (int i = 0; i < DEPTH; i++) step(1, 2'b00, i*4, '0, "R3 final sweep");

    finish_run();
  end

endmodule